// File: doc/BRIEF.md
# Host Word Transfer Handshake Controller

This block carries single 16-bit words between a serial bus protocol core and a host subsystem over a shared parallel bus. The core asks for one transfer at a time, giving the direction and, for writes toward the host, the word. The controller lowers an active-low request toward the host. It waits for an active-low grant, which passes through a two-flop synchronizer. It then runs a fixed-length transfer window with an active-low acknowledge and a two-cycle active-low data strobe centred in that window. Reads from the host are captured where the strobe rises.

When no grant arrives within a parameterised number of cycles, the request is withdrawn and the core is told the transfer failed. A sticky active-low fail flag is also raised toward the host. Only a new-sequence pulse from the protocol core clears that flag. A read/write line turns the data buffers around during requests that need data from the host. A bus output enable lets the block drive the shared bus only during a write window while the host holds its buffer-enable input low.

Top module: `xfer_hs_ctrl`

## Requirements
- R1: While and after a synchronous reset, host_req_n, host_ack_n, host_strobe_n and host_fail_n are 1, and host_rnw, bus_oe, core_done and core_fail are 0.
- R2: A core_req pulse in the idle state drives host_req_n low from the next cycle. host_req_n stays low until the transfer ends or times out. During that time host_rnw equals the latched core_dir (1 means data is read from the host), and host_rnw is 0 whenever host_req_n is high.
- R3: host_grant_n goes through a two-flop synchronizer. If grant is low at the clock edge that ends request cycle k (counting from 1), host_ack_n falls two edges later, provided k is at most TIMEOUT-2. The grant may be released once acknowledge is seen.
- R4: host_ack_n stays low for exactly XFER_CYCLES cycles (default 6), and host_req_n stays low throughout.
- R5: host_strobe_n is low for exactly 2 cycles in each transfer, at acknowledge cycles S and S+1 (0-based), with S = (XFER_CYCLES-2)/2. It is never low outside acknowledge.
- R6: For writes (core_dir = 0), bus_dout holds the word latched with core_req. bus_oe equals "acknowledge low AND buf_en_n low AND host_rnw low" in every cycle.
- R7: For reads (core_dir = 1), core_rdata presents the bus_din value from the last strobe-low cycle, valid from the core_done cycle onward.
- R8: With no grant, host_req_n stays low for exactly TIMEOUT cycles (default 42). It then rises together with a one-cycle core_fail pulse, and host_fail_n goes low.
- R9: host_fail_n stays low across later successful transfers until a seq_start pulse drives it high.
- R10: A core_req pulse that arrives while a transfer is pending is ignored. It does not change the latched word or direction, and no second transfer follows.
- R11: A successful transfer ends with a one-cycle core_done pulse in the same cycle that host_req_n and host_ack_n return high. core_done and core_fail are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (12 MHz in system) |
| rst | input | 1 | Synchronous active-high reset |
| core_req | input | 1 | One-cycle request for one word transfer |
| core_dir | input | 1 | 1 = read word from host, 0 = write word to host |
| core_wdata | input | 16 | Word to send to the host |
| core_rdata | output | 16 | Word read from the host |
| core_done | output | 1 | One-cycle pulse: transfer completed |
| core_fail | output | 1 | One-cycle pulse: grant timed out |
| seq_start | input | 1 | New protocol sequence pulse, clears sticky fail |
| host_req_n | output | 1 | Active-low transfer request |
| host_grant_n | input | 1 | Active-low grant from host (asynchronous) |
| host_ack_n | output | 1 | Active-low transfer acknowledge |
| host_strobe_n | output | 1 | Active-low two-cycle data strobe |
| host_rnw | output | 1 | Buffer direction, high when reading from host |
| host_fail_n | output | 1 | Sticky active-low handshake-fail flag |
| buf_en_n | input | 1 | Active-low host permission to drive the bus |
| bus_oe | output | 1 | Data bus output enable |
| bus_dout | output | 16 | Data driven onto the shared bus |
| bus_din | input | 16 | Data read from the shared bus |

## Verification
A wrong state register shows up at once as a request, acknowledge or read/write line that lingers or is missing. The stimulus looks at these lines every cycle, so such an error is seen in the first transfer that follows it. An off-by-one in the timeout counter or the synchronizer changes which grant delays succeed, so stimulus is aimed at the TIMEOUT-2 and TIMEOUT-1 delays. An error in the transfer window counter moves the strobe within acknowledge, changes the captured read word, or changes the acknowledge length, and each of these is measured on every transfer. A lost or stuck sticky flag differs from the bench's model at the next transfer boundary.

// File: rtl/xfer_hs_pkg.sv
package xfer_hs_pkg;
  localparam int WORD_W = 16;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_MOVE = 2'd2
  } hs_state_t;
endpackage

// File: rtl/xfer_hs_sync.sv
module xfer_hs_sync #(
  parameter int STAGES = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= RST_VAL;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= RST_VAL;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/xfer_hs_timer.sv
module xfer_hs_timer #(
  parameter int LIMIT = 42
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expired
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run)    cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt == LAST);

  // R8
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
  // R8
  run_stop_chk: assert property (@(posedge clk) disable iff (rst)
    expired |=> (cnt == '0) || !run);
endmodule

// File: rtl/xfer_hs_window.sv
module xfer_hs_window #(
  parameter int LEN = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  output logic running,
  output logic last,
  output logic cap,
  output logic strobe_n
);
  localparam int PW = $clog2(LEN);
  localparam int S  = (LEN - 2) / 2;
  localparam logic [PW-1:0] P_LAST = PW'(LEN - 1);
  localparam logic [PW-1:0] P_S    = PW'(S);
  localparam logic [PW-1:0] P_CAP  = PW'(S + 1);

  logic [PW-1:0] phase;
  logic [PW-1:0] phase_inc;

  assign phase_inc = phase + 1'b1;

  function automatic logic in_win(input logic [PW-1:0] p);
    return (p == P_S) || (p == P_CAP);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      running  <= 1'b0;
      phase    <= '0;
      strobe_n <= 1'b1;
    end else if (go && !running) begin
      running  <= 1'b1;
      phase    <= '0;
      strobe_n <= !in_win('0);
    end else if (running) begin
      if (phase == P_LAST) begin
        running  <= 1'b0;
        phase    <= '0;
        strobe_n <= 1'b1;
      end else begin
        phase    <= phase_inc;
        strobe_n <= !in_win(phase_inc);
      end
    end
  end

  assign last = running && (phase == P_LAST);
  assign cap  = running && (phase == P_CAP);

  // R5
  strobe_in_window_chk: assert property (@(posedge clk) disable iff (rst)
    !strobe_n |-> running);
  // R5
  strobe_two_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(strobe_n) |=> !strobe_n ##1 strobe_n);
endmodule

// File: rtl/xfer_hs_ctrl.sv
module xfer_hs_ctrl
  import xfer_hs_pkg::*;
#(
  parameter int TIMEOUT     = 42,
  parameter int XFER_CYCLES = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              core_req,
  input  logic              core_dir,
  input  logic [WORD_W-1:0] core_wdata,
  output logic [WORD_W-1:0] core_rdata,
  output logic              core_done,
  output logic              core_fail,
  input  logic              seq_start,
  output logic              host_req_n,
  input  logic              host_grant_n,
  output logic              host_ack_n,
  output logic              host_strobe_n,
  output logic              host_rnw,
  output logic              host_fail_n,
  input  logic              buf_en_n,
  output logic              bus_oe,
  output logic [WORD_W-1:0] bus_dout,
  input  logic [WORD_W-1:0] bus_din
);
  hs_state_t         state;
  logic              grant_sync_n;
  logic              grant_seen;
  logic              expired;
  logic              win_run, win_last, win_cap;
  logic              go;
  logic [WORD_W-1:0] wdata_q;

  xfer_hs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync (
    .clk (clk),
    .rst (rst),
    .d   (host_grant_n),
    .q   (grant_sync_n)
  );

  assign grant_seen = !grant_sync_n;

  xfer_hs_timer #(.LIMIT(TIMEOUT)) i_timer (
    .clk     (clk),
    .rst     (rst),
    .run     (state == ST_WAIT),
    .expired (expired)
  );

  assign go = (state == ST_WAIT) && grant_seen;

  xfer_hs_window #(.LEN(XFER_CYCLES)) i_win (
    .clk      (clk),
    .rst      (rst),
    .go       (go),
    .running  (win_run),
    .last     (win_last),
    .cap      (win_cap),
    .strobe_n (host_strobe_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      host_req_n  <= 1'b1;
      host_rnw    <= 1'b0;
      host_fail_n <= 1'b1;
      core_done   <= 1'b0;
      core_fail   <= 1'b0;
      wdata_q     <= '0;
      core_rdata  <= '0;
    end else begin
      core_done <= 1'b0;
      core_fail <= 1'b0;
      if (seq_start) host_fail_n <= 1'b1;
      unique case (state)
        ST_IDLE: begin
          if (core_req) begin
            state      <= ST_WAIT;
            host_req_n <= 1'b0;
            host_rnw   <= core_dir;
            wdata_q    <= core_wdata;
          end
        end
        ST_WAIT: begin
          if (grant_seen) begin
            state <= ST_MOVE;
          end else if (expired) begin
            state       <= ST_IDLE;
            host_req_n  <= 1'b1;
            host_rnw    <= 1'b0;
            core_fail   <= 1'b1;
            host_fail_n <= 1'b0;
          end
        end
        ST_MOVE: begin
          if (win_cap && host_rnw) core_rdata <= bus_din;
          if (win_last) begin
            state      <= ST_IDLE;
            host_req_n <= 1'b1;
            host_rnw   <= 1'b0;
            core_done  <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign host_ack_n = !win_run;
  assign bus_dout   = wdata_q;
  assign bus_oe     = win_run && !buf_en_n && !host_rnw;

  // R4
  ack_in_req_chk: assert property (@(posedge clk) disable iff (rst)
    !host_ack_n |-> !host_req_n);
  // R2
  rnw_in_req_chk: assert property (@(posedge clk) disable iff (rst)
    host_rnw |-> !host_req_n);
  // R11
  done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(core_done && core_fail));
  // R8
  fail_flag_chk: assert property (@(posedge clk) disable iff (rst)
    core_fail |-> !host_fail_n && host_req_n);
  // R11
  done_release_chk: assert property (@(posedge clk) disable iff (rst)
    core_done |-> host_req_n && host_ack_n && $past(!host_ack_n));
  // R10
  word_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!host_req_n && $past(!host_req_n)) |-> $stable(bus_dout) && $stable(host_rnw));
endmodule

// File: tb/test_xfer_hs_ctrl.sv
module test_xfer_hs_ctrl;
  localparam int TIMEOUT = 42;
  localparam int LEN     = 6;
  localparam int S       = (LEN - 2) / 2;

  logic clk = 1'b0;
  logic rst;
  logic core_req, core_dir, core_done, core_fail, seq_start;
  logic [15:0] core_wdata, core_rdata, bus_dout, bus_din;
  logic host_req_n, host_grant_n, host_ack_n, host_strobe_n, host_rnw, host_fail_n;
  logic buf_en_n, bus_oe;

  int n_chk = 0;
  int n_bad = 0;
  bit exp_fail_n = 1'b1;

  always #4 clk = ~clk;

  xfer_hs_ctrl #(.TIMEOUT(TIMEOUT), .XFER_CYCLES(LEN)) i_xfer_hs_ctrl (
    .clk(clk), .rst(rst), .core_req(core_req), .core_dir(core_dir),
    .core_wdata(core_wdata), .core_rdata(core_rdata), .core_done(core_done),
    .core_fail(core_fail), .seq_start(seq_start), .host_req_n(host_req_n),
    .host_grant_n(host_grant_n), .host_ack_n(host_ack_n),
    .host_strobe_n(host_strobe_n), .host_rnw(host_rnw),
    .host_fail_n(host_fail_n), .buf_en_n(buf_en_n), .bus_oe(bus_oe),
    .bus_dout(bus_dout), .bus_din(bus_din)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit grant_ok(input int g);
    return (g >= 1) && (g <= TIMEOUT - 2);
  endfunction

  function automatic int exp_req_cycles(input int g);
    return grant_ok(g) ? (g + 2 + LEN) : TIMEOUT;
  endfunction

  task automatic pulse_seq();
    @(negedge clk); seq_start = 1'b1;
    @(negedge clk); seq_start = 1'b0;
    exp_fail_n = 1'b1;
    chk(host_fail_n == 1'b1, "R9", "fail flag after seq_start", host_fail_n, 1);
  endtask

  task automatic run_xfer(input bit dir, input logic [15:0] wd, input int g,
                          input bit bufn, input logic [15:0] din, input bit dup);
    int reqc = 0;
    int ackc = 0;
    int strc = 0;
    int bad_rnw = 0;
    int bad_str = 0;
    int bad_oe = 0;
    int bad_dout = 0;
    int early = 0;
    bit ok = grant_ok(g);
    buf_en_n = bufn;
    bus_din  = din;
    @(negedge clk);
    core_req = 1'b1; core_dir = dir; core_wdata = wd;
    @(negedge clk);
    core_req = 1'b0;
    for (int cyc = 0; cyc < 400; cyc++) begin
      if (host_req_n) break;
      reqc++;
      if (host_rnw !== dir) bad_rnw++;
      if (bus_oe !== (!host_ack_n && !bufn && !dir)) bad_oe++;
      if (!host_ack_n) begin
        if ((host_strobe_n == 1'b0) != (ackc == S || ackc == S + 1)) bad_str++;
        if (!host_strobe_n) strc++;
        if (!dir && bus_dout !== wd) bad_dout++;
        ackc++;
        host_grant_n = 1'b1;
      end else if (!host_strobe_n) bad_str++;
      if (core_done || core_fail) early++;
      if (dup && reqc == 1) begin
        core_req = 1'b1; core_wdata = ~wd; core_dir = !dir;
      end else if (dup && reqc == 2) begin
        core_req = 1'b0;
      end
      if (g >= 1 && reqc == g) host_grant_n = 1'b0;
      @(negedge clk);
    end
    core_req = 1'b0;
    host_grant_n = 1'b1;
    chk(reqc == exp_req_cycles(g), ok ? "R3" : "R8", "request length", reqc, exp_req_cycles(g));
    chk(bad_rnw == 0, "R2", "rnw during request", bad_rnw, 0);
    chk(ackc == (ok ? LEN : 0), "R4", "ack length", ackc, ok ? LEN : 0);
    chk(bad_str == 0 && strc == (ok ? 2 : 0), "R5", "strobe placement", strc, ok ? 2 : 0);
    chk(bad_oe == 0, "R6", "bus_oe mismatches", bad_oe, 0);
    chk(bad_dout == 0, dup ? "R10" : "R6", "write word", bad_dout, 0);
    chk(early == 0, "R11", "early done/fail", early, 0);
    chk(core_done == ok, "R11", "done pulse", core_done, ok);
    chk(core_fail == !ok, "R8", "fail pulse", core_fail, !ok);
    chk(host_rnw == 1'b0 && bus_oe == 1'b0, "R2", "rnw/oe idle", host_rnw, 0);
    if (!ok) exp_fail_n = 1'b0;
    chk(host_fail_n == exp_fail_n, "R9", "sticky fail", host_fail_n, exp_fail_n);
    if (ok && dir) chk(core_rdata == din, "R7", "read word", core_rdata, din);
    @(negedge clk);
    chk(!core_done && !core_fail, "R11", "one-cycle pulse", core_done | core_fail, 0);
    for (int k = 0; k < 4; k++) begin
      if (!host_req_n) early++;
      @(negedge clk);
    end
    chk(early == 0, "R10", "no follow-on request", early, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'hC0DE));
    rst = 1'b1; core_req = 1'b0; core_dir = 1'b0; core_wdata = '0;
    seq_start = 1'b0; host_grant_n = 1'b1; buf_en_n = 1'b0; bus_din = '0;
    repeat (3) @(negedge clk);
    chk(host_req_n && host_ack_n && host_strobe_n && host_fail_n, "R1",
        "idle lines in reset", {host_req_n, host_ack_n, host_strobe_n, host_fail_n}, 15);
    chk(!host_rnw && !bus_oe && !core_done && !core_fail, "R1", "zero outputs in reset",
        {host_rnw, bus_oe, core_done, core_fail}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(host_req_n && host_fail_n, "R1", "idle after reset", {host_req_n, host_fail_n}, 3);

    run_xfer(1'b0, 16'hA5C3, 1, 1'b0, 16'h0000, 1'b0);
    run_xfer(1'b1, 16'h0000, 5, 1'b0, 16'h3C96, 1'b0);
    run_xfer(1'b0, 16'h1234, 3, 1'b1, 16'h0000, 1'b0);
    run_xfer(1'b0, 16'hBEEF, TIMEOUT - 2, 1'b0, 16'h0000, 1'b0);
    run_xfer(1'b1, 16'h0000, TIMEOUT - 1, 1'b0, 16'h7777, 1'b0);
    run_xfer(1'b1, 16'h0000, 4, 1'b0, 16'h8001, 1'b0);
    pulse_seq();
    run_xfer(1'b0, 16'h4242, 0, 1'b0, 16'h0000, 1'b0);
    run_xfer(1'b0, 16'h0F0F, 2, 1'b0, 16'h0000, 1'b1);
    run_xfer(1'b1, 16'h0000, 6, 1'b0, 16'hF00D, 1'b1);
    pulse_seq();

    for (int t = 0; t < 40; t++) begin
      bit dir = 1'($urandom_range(0, 1));
      int g   = int'($urandom_range(0, TIMEOUT + 4));
      if (t % 3 != 0 && g > TIMEOUT - 2) g = int'($urandom_range(1, 10));
      run_xfer(dir, 16'($urandom), g, 1'($urandom_range(0, 1)), 16'($urandom),
               1'($urandom_range(0, 3) == 0));
      if ($urandom_range(0, 3) == 0) pulse_seq();
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule